// File: doc/BRIEF.md
# Whole-Pulse Burst Gate

The block takes a free-running periodic pulse train and an asynchronous gate level. Both come from sources that share no clock. While the gate is held, the block passes the pulses on. It only lets the enable change in the low gap that follows a pulse's falling edge. Because of this, a burst always starts and ends on a pulse boundary, and every pulse sent out has the full input width. A plain AND of gate and pulse can clip a pulse at either end of the gate. That clipping makes the count of output edges vary by one with the gate phase. This block does not show that variation.

Both inputs pass through two-flop synchronizers into one fast system clock domain. A registered copy of the synchronized pulse finds its falling edges. On each falling edge the synchronized gate is sampled into the burst enable. The output is the synchronized pulse ANDed with that enable. A gate held high for N pulse periods gives exactly N pulses, whatever its phase against the train. An 11-bit counter reports how many pulses the current or most recent burst has emitted. An outside checker uses it to confirm exact counts.

Top module: `whole_pulse_gate`

## Requirements
- R1: An active-low synchronous reset drives pulse_out, burst_on and burst_count to 0 on the next clock edge.
- R2: burst_on changes only in the cycle after a falling edge of the synchronized pulse. In the cycle before the change and in the cycle of the change, pulse_out is 0.
- R3: Every high run of pulse_out is exactly as long as the matching high run of pulse_in. An output pulse can only begin when the input pulse rises and only end when it falls.
- R4: A gate held high for exactly N pulse periods (measured in clock cycles) gives exactly N output pulses, for any phase of the gate against the pulse train.
- R5: pulse_out is 0 in every cycle in which burst_on is 0.
- R6: burst_count becomes 0 in the cycle in which burst_on rises. It then rises by 1 one cycle after each rising edge of pulse_out.
- R7: burst_count keeps its value in every cycle that neither follows a rising edge of pulse_out nor starts a burst, including after the burst ends.
- R8: burst_count saturates at 2047 (all ones for the default 11-bit width). Further pulses are still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the pulse train |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Free-running periodic pulse train, asynchronous |
| gate_req | input | 1 | Asynchronous burst request level |
| pulse_out | output | 1 | Gated pulse train, whole pulses only |
| burst_on | output | 1 | Burst enable, switches only between pulses |
| burst_count | output | CNT_W | Pulses emitted in the current or last burst |

## Verification
pulse_out follows pulse_in two cycles later, through the synchronizer. burst_on updates three cycles after a falling edge of pulse_in. burst_count moves one cycle after a rising edge of pulse_out. The bench drives inputs and samples outputs on falling clock edges, so each comparison sees the registered result of the edge before.

Pulse widths, and the rule that no change happens on the enable while a pulse is out, are checked in every sampled cycle. Totals and counter values are compared only after the gate has been low for three pulse periods. By then the last enable update and the last increment have settled.

// File: rtl/whole_pulse_gate.sv
module whole_pulse_gate #(
  parameter int CNT_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             gate_req,
  output logic             pulse_out,
  output logic             burst_on,
  output logic [CNT_W-1:0] burst_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] p_sync, g_sync;
  logic p_last, en;
  logic p_now, g_now, trail, lead;

  assign p_now = p_sync[SYNC_STAGES-1];
  assign g_now = g_sync[SYNC_STAGES-1];
  assign trail = p_last & ~p_now;
  assign lead  = ~p_last & p_now & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_sync <= '0;
      g_sync <= '0;
      p_last <= 1'b0;
    end else begin
      p_sync <= {p_sync[SYNC_STAGES-2:0], pulse_in};
      g_sync <= {g_sync[SYNC_STAGES-2:0], gate_req};
      p_last <= p_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en <= 1'b0;
    else if (trail) en <= g_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      burst_count <= '0;
    else if (trail && g_now && !en)
      burst_count <= '0;
    else if (lead && burst_count != CNT_MAX)
      burst_count <= burst_count + 1'b1;
  end

  assign pulse_out = p_now & en;
  assign burst_on  = en;
endmodule

// File: rtl/whole_pulse_gate_chk.sv
module whole_pulse_gate_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse_out,
  input logic             burst_on,
  input logic [CNT_W-1:0] burst_count,
  input logic             p_now
);
  logic [CNT_W-1:0] cnt_plus;
  assign cnt_plus = burst_count + 1'b1;

  assert_quiet_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on != $past(burst_on)) |-> (!pulse_out && !$past(pulse_out)));

  assert_gated_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |-> !pulse_out);

  assert_whole_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && !$past(pulse_out)) |-> ($past(burst_on) && !$past(p_now)));

  assert_whole_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_out && $past(pulse_out)) |-> (burst_on && !p_now));

  assert_count_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_on) |-> (burst_count == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && !$past(pulse_out)) |=>
      (burst_count == $past(cnt_plus) || $past(burst_count) == '1));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_out && !$past(pulse_out)) |=>
      (burst_count == $past(burst_count) || $rose(burst_on)));
endmodule

bind whole_pulse_gate whole_pulse_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out), .burst_on(burst_on),
  .burst_count(burst_count), .p_now(p_now)
);

// File: tb/whole_pulse_gate_test.sv
module whole_pulse_gate_test;
  localparam int P  = 25;
  localparam int HW = 5;
  localparam int CMAX = 2047;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic gate_req = 1'b0;
  logic pulse_out, burst_on;
  logic [10:0] burst_count;

  int checks = 0, fails = 0;
  int pulses_seen = 0;
  int run = 0;
  int ph = 0;
  bit mon_en = 1'b0;
  bit prev_out = 1'b0, prev_on = 1'b0;
  bit done = 1'b0;

  whole_pulse_gate uut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_req(gate_req),
    .pulse_out(pulse_out), .burst_on(burst_on), .burst_count(burst_count)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    ph = (ph == P-1) ? 0 : ph + 1;
    pulse_in = (ph < HW);
  end

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (pulse_out) run++;
      if (pulse_out && !prev_out) pulses_seen++;
      if (!pulse_out && prev_out) begin
        check(run == HW, "R3 pulse width", run, HW);
        run = 0;
      end
      if (burst_on != prev_on)
        check(!pulse_out && !prev_out, "R2 enable switched during pulse", int'(pulse_out), 0);
      if (!burst_on && pulse_out)
        check(1'b0, "R5 output while disabled", 1, 0);
    end else run = 0;
    prev_out = pulse_out;
    prev_on  = burst_on;
  end

  task automatic t_reset_state();
    check(pulse_out == 0, "R1 pulse_out after reset", int'(pulse_out), 0);
    check(burst_on == 0, "R1 burst_on after reset", int'(burst_on), 0);
    check(burst_count == 0, "R1 burst_count after reset", int'(burst_count), 0);
  endtask

  task automatic t_burst(input int n, input int phase);
    int expc;
    bit saw;
    expc = (n > CMAX) ? CMAX : n;
    saw = 1'b0;
    repeat (phase) @(negedge clk);
    pulses_seen = 0;
    gate_req = 1'b1;
    for (int i = 0; i < n*P; i++) begin
      @(negedge clk);
      if (burst_on && !saw) begin
        saw = 1'b1;
        check(burst_count == 0, "R6 count cleared at burst start", int'(burst_count), 0);
      end
    end
    gate_req = 1'b0;
    repeat (3*P) @(negedge clk);
    check(pulses_seen == n, "R4 pulses per burst", pulses_seen, n);
    check(int'(burst_count) == expc, (n > CMAX) ? "R8 saturated count" : "R6 burst count",
          int'(burst_count), expc);
    check(burst_on == 0, "R2 burst ended", int'(burst_on), 0);
    repeat (2*P + 3) @(negedge clk);
    check(int'(burst_count) == expc, "R7 count held after burst", int'(burst_count), expc);
    check(pulses_seen == n, "R5 no pulses after burst", pulses_seen, n);
  endtask

  task automatic t_reset_mid();
    gate_req = 1'b1;
    repeat (3*P) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    gate_req = 1'b0;
    rst_n = 1'b1;
    pulses_seen = 0;
    repeat (3*P) @(negedge clk);
    check(pulses_seen == 0, "R1 idle after mid-burst reset", pulses_seen, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (2*P) @(negedge clk);
    t_burst(1, 0);
    t_burst(3, 7);
    t_burst(7, 13);
    t_burst(2, 24);
    t_burst(1, 4);
    t_burst(5, 19);
    t_reset_mid();
    t_burst(2050, 3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule